// File: doc/BRIEF.md
# Synchronized Debug Serial Port Slave

This block is the target end of a bit-serial debug link. An external host drives a serial clock and a serial data input. The block returns a word on a serial data output while it takes in the host's word. Both host lines pass through flop synchronizers into the system clock domain. Every rising edge of the synchronized serial clock shifts one data bit in and decrements a bit counter. Half a system clock later, on the falling edge of the system clock, the outgoing register advances to its next bit.

A frame is 17 bits: a status bit, then 16 data bits, most significant first. The counter is tested one system clock after the last edge. When it reaches zero, the received frame is latched for the core and announced by a one-cycle valid pulse. In that same step the outgoing register is loaded with a "busy, try again" word. The core later answers through a valid/response handshake. A success answer carries status 0 and its data, and an error answer carries status 1 and all-ones data. Between frames an answer overwrites the busy word at once. An answer that arrives while a frame is in flight is held until that frame ends, and then it is loaded instead of the busy word.

Top module: `dbg_serial_slave`

## Requirements
- R1: While rst_ni is low, sdo_o is 1, rx_valid_o is 0 and rx_word_o is 0. After a reset in mid-frame, the next 17 serial edges are received as one whole frame.
- R2: Each rising edge of the synchronized sclk_i takes one sdi_i bit. After 17 edges, rx_word_o holds the frame with the first bit received in bit 16 (status position) and the last in bit 0.
- R3: rx_valid_o is a pulse exactly one clk_i cycle long. It occurs once per 17 serial rising edges and never twice in a row.
- R4: sdo_o changes only on falling edges of clk_i. Before the first serial edge of a frame it shows bit 16 of the outgoing word. After each serial rising edge it shows the next lower bit.
- R5: At the end of a frame with no answer pending, the outgoing word becomes the busy word: bit 16 = 1, bits 15:0 = 0x0000.
- R6: A pulse on rsp_valid_i with rsp_err_i low, between frames, makes the next frame return bit 16 = 0 and bits 15:0 = rsp_data_i.
- R7: A pulse on rsp_valid_i with rsp_err_i high makes the returned word bit 16 = 1 and bits 15:0 = 0xFFFF, whatever rsp_data_i holds.
- R8: An answer given while a frame is being shifted does not alter the rest of that frame's output bits. It is loaded at that frame's end in place of the busy word and is returned in the following frame.
- R9: The bit counter reloads at every frame end, so back-to-back frames are each received and answered correctly. It never exceeds 17.
- R10: Changes on sdi_i while sclk_i is steady shift nothing: rx_valid_o stays low, sdo_o stays unchanged and no bit of the next frame is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| sdi_i | input | 1 | Host serial data in, asynchronous |
| sdo_o | output | 1 | Serial data out to host |
| rx_valid_o | output | 1 | One-cycle pulse: new frame latched |
| rx_word_o | output | 17 | Last received frame, status in bit 16 |
| rsp_valid_i | input | 1 | Core answer strobe |
| rsp_err_i | input | 1 | Core answer is an error |
| rsp_data_i | input | 16 | Core answer data |

## Verification
The hardest case to reach is an answer that lands while a frame is only part-way shifted. It must be deferred, and it must replace the busy word exactly at the frame boundary. The bench's frame task can raise the answer strobe between two serial edges. It then checks two things: the remaining output bits of that frame still match the earlier word, and the next frame carries the deferred answer. A reset applied after eight serial edges, followed by a full frame, shows that the bit counter is rearmed.

// File: rtl/dbg_ser_pkg.sv
`timescale 1ns/1ps
package dbg_ser_pkg;
  localparam int  DEF_DATA_W = 16;
  localparam int  DEF_SYNC   = 2;
  localparam logic ST_OK     = 1'b0;
  localparam logic ST_BUSY   = 1'b1;

  function automatic int frame_bits(input int data_w);
    return data_w + 1;
  endfunction
endpackage

// File: rtl/dbg_ser_sync.sv
`timescale 1ns/1ps
module dbg_ser_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dbg_ser_rx.sv
`timescale 1ns/1ps
module dbg_ser_rx #(
  parameter int DATA_W  = 16,
  localparam int FRAME_W = DATA_W + 1,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               step_o,
  output logic               frame_end_o,
  output logic               idle_o,
  output logic               rx_valid_o,
  output logic [FRAME_W-1:0] rx_word_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic               sclk_d_q, step_q, valid_q;
  logic [FRAME_W-1:0] sr_q, word_q;
  logic [CNT_W-1:0]   cnt_q, cnt_base, cnt_d;
  logic               rise, frame_end;

  assign rise      = sclk_i & ~sclk_d_q;
  // counter is tested one cycle after the shift
  assign frame_end = step_q && (cnt_q == '0);
  assign cnt_base  = frame_end ? CNT_FULL : cnt_q;
  assign cnt_d     = rise ? cnt_base - 1'b1 : cnt_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      step_q   <= 1'b0;
      valid_q  <= 1'b0;
      sr_q     <= '0;
      word_q   <= '0;
      cnt_q    <= CNT_FULL;
    end else begin
      sclk_d_q <= sclk_i;
      step_q   <= rise;
      valid_q  <= frame_end;
      cnt_q    <= cnt_d;
      if (rise)      sr_q   <= {sr_q[FRAME_W-2:0], sdi_i};
      if (frame_end) word_q <= sr_q;
    end
  end

  assign step_o      = step_q;
  assign frame_end_o = frame_end;
  assign idle_o      = (cnt_q == CNT_FULL) && !rise;
  assign rx_valid_o  = valid_q;
  assign rx_word_o   = word_q;

  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r9_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  a_r10_no_rise_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_i |=> !step_q);
endmodule

// File: rtl/dbg_ser_tx.sv
`timescale 1ns/1ps
module dbg_ser_tx
  import dbg_ser_pkg::*;
#(
  parameter int DATA_W  = 16,
  localparam int FRAME_W = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              frame_end_i,
  input  logic              idle_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              sdo_o
);
  localparam logic [FRAME_W-1:0] NOT_READY = {ST_BUSY, {DATA_W{1'b0}}};
  localparam logic [FRAME_W-1:0] ERR_WORD  = {ST_BUSY, {DATA_W{1'b1}}};

  logic               pend_q, ld_q;
  logic [FRAME_W-1:0] pend_word_q, ld_word_q, rsp_word, sr_q;

  assign rsp_word = rsp_err_i ? ERR_WORD : {ST_OK, rsp_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_word_q <= NOT_READY;
      ld_q        <= 1'b0;
      ld_word_q   <= NOT_READY;
    end else begin
      ld_q <= 1'b0;
      if (frame_end_i) begin
        ld_q      <= 1'b1;
        ld_word_q <= pend_q ? pend_word_q : NOT_READY;
        pend_q    <= 1'b0;
      end else if (idle_i && pend_q) begin
        ld_q      <= 1'b1;
        ld_word_q <= pend_word_q;
        pend_q    <= 1'b0;
      end
      if (rsp_valid_i) begin
        pend_q      <= 1'b1;
        pend_word_q <= rsp_word;
      end
    end
  end

  // half-period offset: output register runs on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= NOT_READY;
    else if (ld_q)   sr_q <= ld_word_q;
    else if (step_i) sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end

  assign sdo_o = sr_q[FRAME_W-1];

  a_r4_sdo_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i || ld_q) |-> $stable(sdo_o));
  a_r8_no_mid_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !frame_end_i) |=> !ld_q);
endmodule

// File: rtl/dbg_serial_slave.sv
`timescale 1ns/1ps
module dbg_serial_slave
  import dbg_ser_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int SYNC_STAGES = DEF_SYNC,
  localparam int FRAME_W    = DATA_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  output logic               rx_valid_o,
  output logic [FRAME_W-1:0] rx_word_o,
  input  logic               rsp_valid_i,
  input  logic               rsp_err_i,
  input  logic [DATA_W-1:0]  rsp_data_i
);
  logic sclk_s, sdi_s, step, frame_end, idle;

  dbg_ser_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, sdi_i}),
    .q_o    ({sclk_s, sdi_s})
  );

  dbg_ser_rx #(.DATA_W(DATA_W)) i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_s),
    .sdi_i       (sdi_s),
    .step_o      (step),
    .frame_end_o (frame_end),
    .idle_o      (idle),
    .rx_valid_o  (rx_valid_o),
    .rx_word_o   (rx_word_o)
  );

  dbg_ser_tx #(.DATA_W(DATA_W)) i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .frame_end_i (frame_end),
    .idle_i      (idle),
    .rsp_valid_i (rsp_valid_i),
    .rsp_err_i   (rsp_err_i),
    .rsp_data_i  (rsp_data_i),
    .sdo_o       (sdo_o)
  );

  initial assert (FRAME_W == frame_bits(DATA_W));
endmodule

// File: tb/test_dbg_serial_slave.sv
`timescale 1ns/1ps
module test_dbg_serial_slave;
  localparam int HALF = 6;

  typedef struct packed {
    logic [16:0] tx;
    logic [1:0]  mode;   // 0 none, 1 ok, 2 error
    logic [15:0] data;
    logic [16:0] exp;    // word returned during this frame
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{17'h1A5A5, 2'd1, 16'h1234, 17'h10000},
    '{17'h0FFFF, 2'd2, 16'h0F0F, 17'h01234},
    '{17'h10001, 2'd0, 16'h0000, 17'h1FFFF},
    '{17'h08000, 2'd1, 16'hBEEF, 17'h10000},
    '{17'h17E81, 2'd1, 16'h0000, 17'h0BEEF},
    '{17'h00000, 2'd0, 16'h0000, 17'h00000},
    '{17'h1FFFF, 2'd0, 16'h0000, 17'h10000}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sclk = 1'b0, sdi = 1'b0;
  logic        rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [15:0] rsp_data = '0;
  logic        sdo, rx_valid;
  logic [16:0] rx_word;
  int          n_chk = 0, n_fail = 0, vcount = 0;

  always #2.5 clk = ~clk;

  dbg_serial_slave i_dbg_serial_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .rx_valid_o(rx_valid), .rx_word_o(rx_word),
    .rsp_valid_i(rsp_valid), .rsp_err_i(rsp_err), .rsp_data_i(rsp_data)
  );

  always @(negedge clk) if (rst_n && rx_valid) vcount++;

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bits(input logic [16:0] w, input int nbits, input int mid_idx,
                            input logic [15:0] mid_data, output logic [16:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      sdi  = w[16-i];
      sclk = 1'b0;
      if (i == mid_idx) begin
        rsp_valid = 1'b1; rsp_err = 1'b0; rsp_data = mid_data;
        tick(1);
        rsp_valid = 1'b0;
      end
      tick(HALF);
      got[16-i] = sdo;
      sclk = 1'b1;
      tick(HALF);
    end
    sclk = 1'b0;
    tick(HALF);
  endtask

  task automatic respond(input logic [1:0] mode, input logic [15:0] data);
    if (mode != 2'd0) begin
      rsp_valid = 1'b1; rsp_err = (mode == 2'd2); rsp_data = data;
      tick(1);
      rsp_valid = 1'b0;
    end
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [16:0] got, sdo_before;
    int          vc;
    tick(3);
    // R1 reset state
    check("R1 sdo", {16'h0, sdo}, 17'h1);
    check("R1 rx_valid", {16'h0, rx_valid}, 17'h0);
    check("R1 rx_word", rx_word, 17'h0);
    rst_n = 1'b1;
    tick(3);

    // R2 R4 R5 R6 R7 R9: back-to-back frames from the table
    foreach (VECS[k]) begin
      vc = vcount;
      shift_bits(VECS[k].tx, 17, -1, 16'h0, got);
      check("R2 rx_word", rx_word, VECS[k].tx);
      check("R4 R5 R6 R7 R9 returned word", got, VECS[k].exp);
      check("R3 one valid per frame", 17'(vcount - vc), 17'd1);
      respond(VECS[k].mode, VECS[k].data);
    end

    // R10: data toggling with serial clock steady
    vc = vcount;
    sdo_before = {16'h0, sdo};
    for (int t = 0; t < 20; t++) begin
      sdi = ~sdi;
      tick(1);
    end
    tick(6);
    check("R10 sdo unchanged", {16'h0, sdo}, sdo_before);
    check("R10 no valid", 17'(vcount - vc), 17'd0);

    // R8: answer mid-frame is deferred
    vc = vcount;
    shift_bits(17'h03C3C, 17, 5, 16'h5A5A, got);
    check("R8 R10 current frame kept busy word", got, 17'h10000);
    check("R8 R10 rx_word", rx_word, 17'h03C3C);
    check("R3 one valid", 17'(vcount - vc), 17'd1);
    tick(4);
    shift_bits(17'h11111, 17, -1, 16'h0, got);
    check("R8 deferred answer returned", got, 17'h05A5A);
    tick(4);
    shift_bits(17'h00F0F, 17, -1, 16'h0, got);
    check("R5 busy word after deferred answer", got, 17'h10000);

    // R1: reset in mid-frame rearms the counter
    shift_bits(17'h1FFFF, 8, -1, 16'h0, got);
    rst_n = 1'b0;
    tick(2);
    check("R1 sdo in reset", {16'h0, sdo}, 17'h1);
    check("R1 rx_word in reset", rx_word, 17'h0);
    check("R1 rx_valid in reset", {16'h0, rx_valid}, 17'h0);
    rst_n = 1'b1;
    tick(3);
    vc = vcount;
    shift_bits(17'h0ABCD, 17, -1, 16'h0, got);
    check("R1 R2 full frame after reset", rx_word, 17'h0ABCD);
    check("R1 returned word after reset", got, 17'h10000);
    check("R1 R3 one valid after reset", 17'(vcount - vc), 17'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule